// File: doc/BRIEF.md
# Command Queue with Fault Classification

This block holds three small first-in first-out queues of 32-bit command words, each thirteen entries deep, and a sticky fault register that records every misuse of them. Queue 0 carries reseed commands, queue 1 carries generate commands and queue 2 carries output words. Each queue has a push strobe with write data, a pop strobe, a read-data output that always shows the oldest entry, and full and empty flags.

Every misuse is classified. A push into a full queue, a pop from an empty queue, and a queue whose full and empty flags are both raised each set a fault-type bit. The offending queue also sets its own source bit. Such a push or pop is blocked, so the queue contents stay intact. The fault bits stay set until reset, and a single fatal output reports that any bit is set.

A four-bit clear code empties the two command queues and holds them empty. The output queue is not cleared. A test strobe with a five-bit index forces a single fault pulse on any bit of the fault register, so the paths that consume the fault can be checked.

Top module: `cmdq_fault_unit`

## Requirements
- R1: Each queue holds up to 13 words and returns them in the order they were pushed. `rdata_o` shows the oldest entry whenever the queue is not empty.
- R2: `full_o[i]` is high exactly when queue i holds 13 words, and `empty_o[i]` is high exactly when it holds none. After reset every queue is empty and not full.
- R3: A push into a full queue is dropped and the stored words are unchanged. On the next cycle, fault bit 28 and the queue's source bit are set.
- R4: A pop from an empty queue changes nothing in the queue. On the next cycle, fault bit 29 and the queue's source bit are set.
- R5: The source bits are bit 0 for queue 0 (reseed), bit 1 for queue 1 (generate) and bit 2 for queue 2 (output). No other source bit is set by a fault on that queue.
- R6: Fault bits never clear except by reset. `fatal_o` is high whenever any fault bit is set.
- R7: While `clr_code_i` equals 4'b1010, queues 0 and 1 are empty from the next cycle on. Queue 2 keeps its contents.
- R8: Any `clr_code_i` value other than 4'b0101 holds queues 0 and 1 empty. Pushes and pops to them are ignored and record no fault. Once the code returns to 4'b0101, pushes are accepted again.
- R9: A cycle with `test_we_i` high sets fault bit `test_idx_i` on the next cycle. Bit 30, the full-and-empty type, is otherwise set only when a queue's full and empty flags are both high.
- R10: A push and a pop on the same cycle both take effect when the queue is neither full nor empty. When the queue is full, the pop takes effect and the push is dropped as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_code_i | input | 4 | Clear code for queues 0 and 1; 4'b0101 means idle |
| push_i | input | 3 | Push strobe, one per queue |
| wdata_i | input | 96 | Write words; queue i uses bits i*32 +: 32 |
| pop_i | input | 3 | Pop strobe, one per queue |
| rdata_o | output | 96 | Oldest word of each queue; queue i at bits i*32 +: 32 |
| full_o | output | 3 | Queue holds 13 words |
| empty_o | output | 3 | Queue holds no words |
| test_we_i | input | 1 | Inject a fault pulse this cycle |
| test_idx_i | input | 5 | Bit position of the injected pulse |
| err_code_o | output | 32 | Sticky fault register |
| fatal_o | output | 1 | Any fault bit set |

## Verification
The full-and-empty fault cannot be produced from the ports. The flags follow a single occupancy count, so a working queue never raises both at once. The bench therefore reaches bit 30 through the injection strobe and checks that it lands alone and then stays set. An overflow needs thirteen accepted pushes before the fourteenth, so the overflow scenario first fills a queue to its limit. It then drains the queue to show that the rejected word never entered.

// File: rtl/cmdq_fault_pkg.sv
package cmdq_fault_pkg;
    localparam int unsigned CODE_W       = 32;
    localparam int unsigned IDX_W        = $clog2(CODE_W);
    localparam int unsigned WR_FAULT_BIT = 28;
    localparam int unsigned RD_FAULT_BIT = 29;
    localparam int unsigned ST_FAULT_BIT = 30;

    localparam logic [3:0] CLR_ON  = 4'b1010;
    localparam logic [3:0] CLR_OFF = 4'b0101;

    typedef struct packed {
        logic wr;
        logic rd;
        logic st;
    } fault_t;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo
    import cmdq_fault_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             full_o,
    output logic             empty_o,
    output fault_t           fault_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wptr;
        logic [PTR_W-1:0]            rptr;
        logic [CNT_W-1:0]            cnt;
        logic                        full;
        logic                        empty;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_wr, do_rd;

    always_comb begin
        st_d  = st_q;
        do_wr = push_i & ~st_q.full & ~clr_i;
        do_rd = pop_i & ~st_q.empty & ~clr_i;
        if (clr_i) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.cnt   = '0;
            st_d.full  = 1'b0;
            st_d.empty = 1'b1;
        end else begin
            if (do_wr) begin
                st_d.mem[st_q.wptr] = wdata_i;
                st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + PTR_W'(1);
            end
            if (do_rd) begin
                st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + PTR_W'(1);
            end
            st_d.cnt   = st_q.cnt + CNT_W'(do_wr) - CNT_W'(do_rd);
            st_d.full  = (st_d.cnt == CNT_W'(DEPTH));
            st_d.empty = (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o     = st_q.mem[st_q.rptr];
    assign full_o      = st_q.full;
    assign empty_o     = st_q.empty;
    assign fault_o.wr  = push_i & st_q.full & ~clr_i;
    assign fault_o.rd  = pop_i & st_q.empty & ~clr_i;
    assign fault_o.st  = st_q.full & st_q.empty;
endmodule

// File: rtl/cmdq_err_log.sv
module cmdq_err_log
    import cmdq_fault_pkg::*;
#(
    parameter int unsigned N_SRC = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  fault_t [N_SRC-1:0]    fault_i,
    input  logic                  inj_we_i,
    input  logic [IDX_W-1:0]      inj_idx_i,
    output logic [CODE_W-1:0]     code_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } log_st_t;

    log_st_t           st_d, st_q;
    logic [CODE_W-1:0] pulse;

    always_comb begin
        pulse = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            pulse[i]            = pulse[i] | fault_i[i].wr | fault_i[i].rd | fault_i[i].st;
            pulse[WR_FAULT_BIT] = pulse[WR_FAULT_BIT] | fault_i[i].wr;
            pulse[RD_FAULT_BIT] = pulse[RD_FAULT_BIT] | fault_i[i].rd;
            pulse[ST_FAULT_BIT] = pulse[ST_FAULT_BIT] | fault_i[i].st;
        end
        if (inj_we_i) begin
            pulse[inj_idx_i] = 1'b1;
        end
        st_d.code = st_q.code | pulse;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/cmdq_fault_unit.sv
module cmdq_fault_unit
    import cmdq_fault_pkg::*;
#(
    parameter int unsigned         N_FIFO   = 3,
    parameter int unsigned         WIDTH    = 32,
    parameter int unsigned         DEPTH    = 13,
    parameter logic [N_FIFO-1:0]   CLR_MASK = 3'b011
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [3:0]                clr_code_i,
    input  logic [N_FIFO-1:0]         push_i,
    input  logic [N_FIFO*WIDTH-1:0]   wdata_i,
    input  logic [N_FIFO-1:0]         pop_i,
    output logic [N_FIFO*WIDTH-1:0]   rdata_o,
    output logic [N_FIFO-1:0]         full_o,
    output logic [N_FIFO-1:0]         empty_o,
    input  logic                      test_we_i,
    input  logic [IDX_W-1:0]          test_idx_i,
    output logic [CODE_W-1:0]         err_code_o,
    output logic                      fatal_o
);
    fault_t [N_FIFO-1:0] faults;
    logic                clr_on;

    assign clr_on = (clr_code_i != CLR_OFF);

    for (genvar i = 0; i < int'(N_FIFO); i++) begin : g_q
        logic q_clr;
        assign q_clr = CLR_MASK[i] & clr_on;

        cmdq_fifo #(
            .WIDTH (WIDTH),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (q_clr),
            .push_i  (push_i[i]),
            .wdata_i (wdata_i[i*WIDTH +: WIDTH]),
            .pop_i   (pop_i[i]),
            .rdata_o (rdata_o[i*WIDTH +: WIDTH]),
            .full_o  (full_o[i]),
            .empty_o (empty_o[i]),
            .fault_o (faults[i])
        );
    end

    cmdq_err_log #(
        .N_SRC (N_FIFO)
    ) u_log (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fault_i   (faults),
        .inj_we_i  (test_we_i),
        .inj_idx_i (test_idx_i),
        .code_o    (err_code_o)
    );

    assign fatal_o = |err_code_o;
endmodule

// File: rtl/cmdq_fault_unit_chk.sv
module cmdq_fault_unit_chk
    import cmdq_fault_pkg::*;
#(
    parameter int unsigned       N_FIFO   = 3,
    parameter logic [N_FIFO-1:0] CLR_MASK = 3'b011
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [3:0]          clr_code_i,
    input logic [N_FIFO-1:0]   push_i,
    input logic [N_FIFO-1:0]   pop_i,
    input logic [N_FIFO-1:0]   full_o,
    input logic [N_FIFO-1:0]   empty_o,
    input logic                test_we_i,
    input logic [IDX_W-1:0]    test_idx_i,
    input logic [CODE_W-1:0]   err_code_o
);
    logic [N_FIFO-1:0] held;
    assign held = (clr_code_i != CLR_OFF) ? CLR_MASK : '0;

    // R2
    flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o & empty_o) == '0);

    // R3
    wr_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |(push_i & full_o & ~held) |=> err_code_o[WR_FAULT_BIT]);

    // R4
    rd_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |(pop_i & empty_o & ~held) |=> err_code_o[RD_FAULT_BIT]);

    // R6
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_code_o & $past(err_code_o)) == $past(err_code_o));

    // R7
    clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_code_i == CLR_ON) |=> ((empty_o & CLR_MASK) == CLR_MASK));

    // R8
    clear_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_code_i != CLR_OFF) |=> ((empty_o & CLR_MASK) == CLR_MASK));

    // R9
    inject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        test_we_i |=> err_code_o[$past(test_idx_i)]);
endmodule

bind cmdq_fault_unit cmdq_fault_unit_chk #(
    .N_FIFO   (N_FIFO),
    .CLR_MASK (CLR_MASK)
) u_chk (.*);

// File: tb/cmdq_fault_unit_test.sv
module cmdq_fault_unit_test;
    import cmdq_fault_pkg::*;

    localparam int N = 3;
    localparam int W = 32;
    localparam int D = 13;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     clr_code = CLR_OFF;
    logic [N-1:0]   push = '0;
    logic [N*W-1:0] wdata = '0;
    logic [N-1:0]   pop = '0;
    logic [N*W-1:0] rdata;
    logic [N-1:0]   full, empty;
    logic           test_we = 1'b0;
    logic [4:0]     test_idx = '0;
    logic [31:0]    err_code;
    logic           fatal;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cmdq_fault_unit uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .clr_code_i (clr_code),
        .push_i     (push),
        .wdata_i    (wdata),
        .pop_i      (pop),
        .rdata_o    (rdata),
        .full_o     (full),
        .empty_o    (empty),
        .test_we_i  (test_we),
        .test_idx_i (test_idx),
        .err_code_o (err_code),
        .fatal_o    (fatal)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] rd(int f);
        return rdata[f*W +: W];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        push = '0;
        pop = '0;
        test_we = 1'b0;
        clr_code = CLR_OFF;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic push_one(int f, logic [31:0] v);
        wdata[f*W +: W] = v;
        push[f] = 1'b1;
        tick();
        push[f] = 1'b0;
    endtask

    task automatic pop_one(int f);
        pop[f] = 1'b1;
        tick();
        pop[f] = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R2", "empty after reset", 32'(empty), 32'h7);
        check("R2", "full after reset", 32'(full), 32'h0);
        check("R6", "code after reset", err_code, 32'h0);
        check("R6", "fatal after reset", 32'(fatal), 32'h0);
    endtask

    task automatic t_order();
        do_reset();
        for (int k = 0; k < D; k++) begin
            push_one(1, 32'hC0DE_0000 + k);
            if (k == D - 2) check("R2", "not full at 12", 32'(full[1]), 32'h0);
        end
        check("R2", "full at 13", 32'(full[1]), 32'h1);
        check("R1", "oldest word shown", rd(1), 32'hC0DE_0000);
        check("R1", "no fault on fill", err_code, 32'h0);
        // R10: push and pop together while full
        wdata[1*W +: W] = 32'hDEAD_BEEF;
        push[1] = 1'b1;
        pop[1] = 1'b1;
        tick();
        check("R10", "full push+pop fault", err_code, (32'h1 << 1) | (32'h1 << 28));
        check("R10", "pop taken when full", rd(1), 32'hC0DE_0001);
        check("R10", "not full after", 32'(full[1]), 32'h0);
        // R10: push and pop together, neither full nor empty
        wdata[1*W +: W] = 32'h5555_AAAA;
        tick();
        push[1] = 1'b0;
        pop[1] = 1'b0;
        check("R10", "both taken", rd(1), 32'hC0DE_0002);
        for (int k = 2; k < D; k++) begin
            check("R1", "drain order", rd(1), 32'hC0DE_0000 + k);
            pop_one(1);
        end
        check("R10", "pushed word last", rd(1), 32'h5555_AAAA);
        pop_one(1);
        check("R2", "empty after drain", 32'(empty[1]), 32'h1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 0; k < D; k++) push_one(0, 32'h1000_0000 + k);
        push_one(0, 32'hFFFF_FFFF);
        check("R3", "overflow code", err_code, (32'h1 << 0) | (32'h1 << 28));
        check("R6", "fatal on overflow", 32'(fatal), 32'h1);
        for (int k = 0; k < D; k++) begin
            check("R3", "contents intact", rd(0), 32'h1000_0000 + k);
            pop_one(0);
        end
        check("R3", "extra word dropped", 32'(empty[0]), 32'h1);
    endtask

    task automatic t_underflow();
        do_reset();
        pop_one(2);
        check("R4", "underflow code", err_code, (32'h1 << 2) | (32'h1 << 29));
        check("R4", "still empty", 32'(empty), 32'h7);
        for (int k = 0; k < 5; k++) tick();
        check("R6", "code held", err_code, (32'h1 << 2) | (32'h1 << 29));
        pop_one(1);
        check("R5", "second source bit", err_code, (32'h1 << 1) | (32'h1 << 2) | (32'h1 << 29));
        do_reset();
        check("R6", "reset clears code", err_code, 32'h0);
    endtask

    task automatic t_clear();
        do_reset();
        push_one(0, 32'hA000_0000);
        push_one(1, 32'hB000_0000);
        push_one(2, 32'hE000_0000);
        push_one(2, 32'hE000_0001);
        clr_code = CLR_ON;
        tick();
        check("R7", "command queues emptied", 32'(empty), 32'h3);
        check("R7", "output queue kept", rd(2), 32'hE000_0000);
        push_one(0, 32'hA000_0001);
        check("R8", "push ignored under clear", 32'(empty[0]), 32'h1);
        clr_code = 4'b0011;
        push_one(1, 32'hB000_0001);
        pop_one(0);
        check("R8", "invalid code holds empty", 32'(empty[1:0]), 32'h3);
        check("R8", "no fault under clear", err_code, 32'h0);
        clr_code = CLR_OFF;
        push_one(0, 32'h7777_0001);
        check("R8", "push accepted again", 32'(empty[0]), 32'h0);
        check("R8", "accepted word", rd(0), 32'h7777_0001);
    endtask

    task automatic t_inject();
        do_reset();
        test_idx = 5'd30;
        test_we = 1'b1;
        tick();
        test_we = 1'b0;
        check("R9", "bit 30 alone", err_code, 32'h1 << 30);
        check("R9", "fatal from inject", 32'(fatal), 32'h1);
        tick();
        check("R6", "inject sticky", err_code, 32'h1 << 30);
        test_idx = 5'd5;
        test_we = 1'b1;
        tick();
        test_we = 1'b0;
        check("R9", "bit 5 added", err_code, (32'h1 << 30) | (32'h1 << 5));
    endtask

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_overflow();
        t_underflow();
        t_clear();
        t_inject();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule